// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one output cell of a small sum-of-products logic array. The product-term inputs come from an AND array outside the block. The cell ORs the terms that carry data and then either passes the sum straight through or captures it in a flip-flop. A polarity bit can invert the result. The cell drives a pad as two separate signals, a data value and an output enable, and it sends one signal back to the array as feedback.

Two bits shared by every cell in the array set the cell's global mode, and two bits of its own set its local behaviour. Together these bits decide four things: the role of product term zero (a data term or the output enable), the source of the output enable, whether the flip-flop drives the pad, and the source of the feedback. A separate mask bit for each product term can switch that term off.

The global mode is encoded as follows. 2'b00 is simple mode, 2'b01 is complex mode, and 2'b10 and 2'b11 are both registered mode. Local bit 0 selects polarity: 1 inverts the output. The meaning of local bit 1 depends on the global mode, as the requirements below set out.

Top module: `pal_out_cell`

## Requirements
- R1: The sum is the OR of the enabled data terms. Terms 1 to 7 are always data. Term 0 is data only in simple mode, or in registered mode with local bit 1 = 1. In every other case term 0 is the enable term and does not enter the sum.
- R2: A term whose `term_off_i` bit is 1 contributes 0. With every term masked, a combinatorial output shows 0, or 1 when inverted.
- R3: When `loc_mode_i[0]` = 1, `pad_do_o` is the complement of the selected value (the sum or the flip-flop). When it is 0, `pad_do_o` is that value unchanged.
- R4: In registered mode with `loc_mode_i[1]` = 1 (a registered cell), `pad_do_o` shows the sum captured at the latest rising edge of `clk`, XOR the polarity bit. Input changes between edges do not move it.
- R5: The flip-flop is cleared while `rst_n` is low. A registered, inverting cell therefore drives `pad_do_o` = 1 during and just after reset.
- R6: In simple mode, `pad_oe_o` = 1 when `loc_mode_i[1]` = 0 (dedicated output). It is 0 when `loc_mode_i[1]` = 1 (dedicated input).
- R7: In complex mode, `pad_oe_o` equals the masked term 0 when `loc_mode_i[1]` = 0. It is 0 when `loc_mode_i[1]` = 1.
- R8: In registered mode, a registered cell takes `pad_oe_o` from the shared pin `oe_pin_i`. A combinatorial cell (`loc_mode_i[1]` = 0) takes it from the masked term 0.
- R9: When term 0 is the enable term and its `term_off_i[0]` = 1, `pad_oe_o` = 0 whatever the term's value.
- R10: The feedback `fb_o` comes from one of three sources. It is `pin_in_i` in complex mode, in simple mode with `loc_mode_i[1]` = 1, and in a registered-mode combinatorial cell. It is `adj_pin_i` in simple mode with `loc_mode_i[1]` = 0. It is the true (uninverted) flip-flop value in a registered cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock for the flip-flop |
| rst_n | input | 1 | Active-low asynchronous clear of the flip-flop |
| glb_mode_i | input | 2 | Global mode bits shared by all cells |
| loc_mode_i | input | 2 | Local bits: [0] polarity, [1] mode-dependent role |
| terms_i | input | NTERMS | Product terms from the AND array |
| term_off_i | input | NTERMS | Per-term disable mask, 1 = forced inactive |
| oe_pin_i | input | 1 | Shared output-enable pin used by registered cells |
| pin_in_i | input | 1 | Level sensed on this cell's own pad |
| adj_pin_i | input | 1 | Level sensed on the neighbouring cell's pad |
| pad_do_o | output | 1 | Pad data value |
| pad_oe_o | output | 1 | Pad output enable |
| fb_o | output | 1 | Feedback signal to the AND array |

## Verification
The case that is hardest to reach is a registered cell whose term inputs change between clock edges. The pad must keep the captured value, and it must not be confused with the combinatorial sum of the new inputs. The bench reaches this case directly. After each capture edge it drives the complement of the term vector, then checks that the pad has not moved until the next edge. The sweep covers every global and local mode, every term vector and several mask patterns. It therefore also reaches the enable term masked in each mode that uses it for the enable, and the register feedback, which is visible only through `fb_o`.

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
  parameter int NTERMS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        glb_mode_i,
  input  logic [1:0]        loc_mode_i,
  input  logic [NTERMS-1:0] terms_i,
  input  logic [NTERMS-1:0] term_off_i,
  input  logic              oe_pin_i,
  input  logic              pin_in_i,
  input  logic              adj_pin_i,
  output logic              pad_do_o,
  output logic              pad_oe_o,
  output logic              fb_o
);

  logic simple_m, complex_m, reg_m, reg_cell, t0_data, sum, q;
  logic [NTERMS-1:0] live;

  assign simple_m  = (glb_mode_i == 2'b00);
  assign complex_m = (glb_mode_i == 2'b01);
  assign reg_m     = glb_mode_i[1];
  assign reg_cell  = reg_m & loc_mode_i[1];
  assign t0_data   = simple_m | reg_cell;

  assign live = terms_i & ~term_off_i;
  assign sum  = |(live & {{(NTERMS-1){1'b1}}, t0_data});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= 1'b0;
    else        q <= sum;

  assign pad_do_o = (reg_cell ? q : sum) ^ loc_mode_i[0];

  always_comb begin
    if (simple_m)        pad_oe_o = ~loc_mode_i[1];
    else if (complex_m)  pad_oe_o = ~loc_mode_i[1] & live[0];
    else                 pad_oe_o = loc_mode_i[1] ? oe_pin_i : live[0];
  end

  always_comb begin
    if (simple_m)        fb_o = loc_mode_i[1] ? pin_in_i : adj_pin_i;
    else if (reg_cell)   fb_o = q;
    else                 fb_o = pin_in_i;
  end

  // R6
  ded_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (simple_m && loc_mode_i[1]) |-> !pad_oe_o);

  // R9
  oe_term_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!simple_m && !loc_mode_i[1] && term_off_i[0]) |-> !pad_oe_o);

  // R2
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&term_off_i && !reg_cell) |-> (pad_do_o == loc_mode_i[0]));

  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_cell && $past(&term_off_i)) |-> (pad_do_o == loc_mode_i[0]));

  // R8
  reg_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cell |-> (pad_oe_o == oe_pin_i));

  // R10
  fb_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_cell |-> (fb_o == (pad_do_o ^ loc_mode_i[0])));

endmodule

// File: tb/tb_pal_out_cell.sv
`timescale 1ns/100ps
module tb_pal_out_cell;
  logic clk = 0, rst_n = 0;
  logic [1:0] glb, loc;
  logic [7:0] terms, off;
  logic oe_pin, pin_in, adj;
  logic pad_do, pad_oe, fb;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic exp_q;

  always #2 clk = ~clk;

  pal_out_cell #(.NTERMS(8)) dut (
    .clk(clk), .rst_n(rst_n), .glb_mode_i(glb), .loc_mode_i(loc),
    .terms_i(terms), .term_off_i(off), .oe_pin_i(oe_pin),
    .pin_in_i(pin_in), .adj_pin_i(adj),
    .pad_do_o(pad_do), .pad_oe_o(pad_oe), .fb_o(fb));

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s glb=%b loc=%b terms=%h off=%h act=%b exp=%b",
               req, glb, loc, terms, off, act, exp);
    end
  endtask

  function automatic logic f_sum(logic [1:0] g, logic [1:0] l, logic [7:0] t, logic [7:0] o);
    logic t0d = (g == 2'b00) || (g[1] && l[1]);
    return |(t & ~o & {7'h7F, t0d});
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [5];
    offs = '{8'h00, 8'h01, 8'hFE, 8'hFF, 8'h55};
    glb = 2'b10; loc = 2'b11; terms = 8'hFF; off = 8'h00;
    oe_pin = 0; pin_in = 0; adj = 0;
    repeat (3) @(posedge clk);
    #1;
    // R5: cleared flip-flop, inverted pad reads high, feedback low
    chk("R5", pad_do, 1'b1);
    chk("R5", fb, 1'b0);
    @(negedge clk) rst_n = 1;
    exp_q = 0;
    for (int g = 0; g < 4; g++)
      for (int l = 0; l < 4; l++)
        for (int k = 0; k < 5; k++)
          for (int t = 0; t < 256; t++)
            for (int p = 0; p < 2; p++) begin
              logic s, t0e, rc, eoe, efb, edo;
              @(negedge clk);
              glb = g[1:0]; loc = l[1:0]; terms = t[7:0]; off = offs[k];
              oe_pin = p[0]; pin_in = terms[3] ^ terms[6]; adj = terms[5] ^ p[0];
              @(posedge clk);
              s = f_sum(glb, loc, terms, off);
              exp_q = s;
              #1;
              rc  = glb[1] && loc[1];
              t0e = terms[0] & ~off[0];
              if (glb == 2'b00)      eoe = ~loc[1];
              else if (glb == 2'b01) eoe = loc[1] ? 1'b0 : t0e;
              else                   eoe = loc[1] ? oe_pin : t0e;
              if (glb == 2'b00)      efb = loc[1] ? pin_in : adj;
              else if (rc)           efb = exp_q;
              else                   efb = pin_in;
              edo = (rc ? exp_q : s) ^ loc[0];
              // R1 R2 R3 sum, masking and polarity; R4 capture
              chk(rc ? "R4" : (off == 8'hFF ? "R2" : (loc[0] ? "R3" : "R1")), pad_do, edo);
              // R6 R7 R8 R9 enable source
              chk(glb == 2'b00 ? "R6" : (glb == 2'b01 ? (off[0] && !loc[1] ? "R9" : "R7") : "R8"), pad_oe, eoe);
              // R10 feedback source
              chk("R10", fb, efb);
              if (rc) begin
                terms = ~terms;
                #0.5;
                // R4: no movement between edges
                chk("R4", pad_do, edo);
              end
            end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule